// File: doc/BRIEF.md
# Receive Elastic Ring Buffer

This block moves received symbols from the recovered receive clock into the user receive clock through a 64-entry circular store. Every entry is 13 bits wide: a data field of up to 10 bits and a 3-bit status field that travels with it. On each write-clock edge, while the buffer is in use, the block stores one entry. On each read-clock edge, once the read side has been armed, it returns one entry. Neither side waits for the other. The clocks are expected to differ only slightly, so any drift between them shows up as a slow change in fill level.

Reset does not leave the store empty. It puts the write pointer half a ring ahead of the read pointer, so the first written entry comes out after a fixed delay and the buffer has equal slack in both directions. The write pointer crosses into the read domain in Gray code. The read side computes the fill level from it and reports a sticky error code when the fill level drifts outside an inner band.

A bypass select sends the incoming word around the store, registered once on the write clock. While bypass is selected, both pointers are held at their reset positions and the error code is held clear.

Top module: `rx_elastic_ring`

## Requirements
- R1: With bypass low, every write-clock edge stores {status, data} at the write pointer and every armed read-clock edge returns the next stored entry. Entries come out in write order, with the status bits matched to their data.
- R2: When `narrow` is high, bits 9:8 of the stored data are forced to zero and bits 7:0 are kept. When `narrow` is low, all 10 data bits are kept.
- R3: After reset is released, the write pointer starts at 32 and the read pointer at 0. The first read-clock edge after release only arms the read side. The entry from the first write after release therefore appears on `rd_data` after the 34th read-clock edge.
- R4: When the fill level (write pointer seen in the read domain, minus read pointer, modulo 64) is below 17, `err_code` becomes 2'b01 on the next read-clock edge. With no writes after release, this happens at the 18th read-clock edge and not at the 17th.
- R5: When the fill level is above 57, `err_code` becomes 2'b10 on the next read-clock edge.
- R6: Once `err_code` is non-zero, it keeps its value, even if the fill level later crosses the other threshold, until reset is applied or bypass is selected.
- R7: `rst` clears `err_code` to 2'b00 at once, without waiting for a clock edge.
- R8: While `bypass` is high, `rd_data` and `rd_stat` show `wr_data` and `wr_stat` as captured at the last write-clock edge. `narrow` has no effect on this path.
- R9: While `bypass` is high, `err_code` is 2'b00 and both pointers are held at their reset positions. Releasing bypass gives the same fill timing as releasing reset.
- R10: When both clocks run at the same rate, `err_code` stays 2'b00.
- R11: `err_code` never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock (write side) |
| rd_clk | input | 1 | User receive clock (read side) |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| bypass | input | 1 | 1 = send data around the store |
| narrow | input | 1 | 1 = 8-bit data path, 0 = 10-bit data path |
| wr_data | input | 10 | Incoming data symbol |
| wr_stat | input | 3 | Incoming status bits |
| rd_data | output | 10 | Outgoing data symbol |
| rd_stat | output | 3 | Outgoing status bits |
| err_code | output | 2 | 00 normal, 01 underflow, 10 overflow (sticky) |

## Verification
The hardest states to reach are the two error codes. At equal clock rates the fill level never leaves its band, and the write side cannot be slowed from the ports. The bench therefore drives the write clock from a generator that can be stopped or run at twice the read rate. With the write clock stopped, the fill level falls by exactly one per read edge, so the underflow edge can be checked cycle by cycle. The same stopped-clock method, applied after a bypass release, shows that bypass really parks the pointers at half full.

// File: rtl/rxeb_pkg.sv
package rxeb_pkg;

  localparam int RXEB_FN_W = 16;

  typedef logic [RXEB_FN_W-1:0] rxeb_word_t;

  typedef enum logic [1:0] {
    RXEB_OK    = 2'b00,
    RXEB_UNDER = 2'b01,
    RXEB_OVER  = 2'b10
  } rxeb_err_e;

  function automatic rxeb_word_t rxeb_to_gray(input rxeb_word_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic rxeb_word_t rxeb_from_gray(input rxeb_word_t g);
    rxeb_word_t b;
    b[RXEB_FN_W-1] = g[RXEB_FN_W-1];
    for (int i = RXEB_FN_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // occupancy modulo 2**pw
  function automatic rxeb_word_t rxeb_fill(input rxeb_word_t wr, input rxeb_word_t rd,
                                           input int unsigned pw);
    rxeb_word_t mask;
    mask = (rxeb_word_t'(1) << pw) - rxeb_word_t'(1);
    return (wr - rd) & mask;
  endfunction

  function automatic rxeb_err_e rxeb_judge(input rxeb_word_t fill,
                                           input int unsigned over_above,
                                           input int unsigned under_below);
    if (32'(fill) > over_above) return RXEB_OVER;
    if (32'(fill) < under_below) return RXEB_UNDER;
    return RXEB_OK;
  endfunction

endpackage

// File: rtl/rxeb_gray_sync.sv
module rxeb_gray_sync #(
  parameter int unsigned W = 6,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rxeb_wr_side.sv
module rxeb_wr_side
  import rxeb_pkg::*;
#(
  parameter int unsigned PTR_W    = 6,
  parameter int unsigned DATA_W   = 10,
  parameter int unsigned STAT_W   = 3,
  parameter int unsigned NARROW_W = 8,
  parameter int unsigned ENT_W    = DATA_W + STAT_W
) (
  input  logic              wr_clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              narrow,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_stat,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  wr_gray,
  output logic [ENT_W-1:0]  wr_entry,
  output logic [ENT_W-1:0]  byp_entry
);

  localparam logic [PTR_W-1:0] HALF   = PTR_W'(1 << (PTR_W - 1));
  localparam logic [PTR_W-1:0] HALF_G = HALF ^ (HALF >> 1);

  logic [DATA_W-1:0] data_kept;
  logic [PTR_W-1:0]  ptr_nxt;

  generate
    if (DATA_W > NARROW_W) begin : g_mask
      assign data_kept = narrow ? {{(DATA_W - NARROW_W){1'b0}}, wr_data[NARROW_W-1:0]}
                                : wr_data;
    end else begin : g_pass
      assign data_kept = wr_data;
    end
  endgenerate

  assign ptr_nxt  = bypass ? HALF : wr_ptr + 1'b1;
  assign wr_en    = !bypass;
  assign wr_entry = {wr_stat, data_kept};

  always_ff @(posedge wr_clk or posedge rst) begin
    if (rst) begin
      wr_ptr    <= HALF;
      wr_gray   <= HALF_G;
      byp_entry <= '0;
    end else begin
      wr_ptr    <= ptr_nxt;
      wr_gray   <= PTR_W'(rxeb_to_gray(rxeb_word_t'(ptr_nxt)));
      byp_entry <= {wr_stat, wr_data};
    end
  end

endmodule

// File: rtl/rxeb_ram.sv
module rxeb_ram #(
  parameter int unsigned AW    = 6,
  parameter int unsigned ENT_W = 13
) (
  input  logic             wr_clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic             rd_clk,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [ENT_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/rxeb_rd_side.sv
module rxeb_rd_side
  import rxeb_pkg::*;
#(
  parameter int unsigned PTR_W       = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVER_ABOVE  = 57,
  parameter int unsigned UNDER_BELOW = 17
) (
  input  logic             rd_clk,
  input  logic             rst,
  input  logic             bypass,
  input  logic [PTR_W-1:0] wr_gray_async,
  output logic             rd_en,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] fill,
  output logic             unf_evt,
  output logic             ovf_evt,
  output logic [1:0]       err_code
);

  localparam logic [PTR_W-1:0] HALF   = PTR_W'(1 << (PTR_W - 1));
  localparam logic [PTR_W-1:0] HALF_G = HALF ^ (HALF >> 1);

  logic [PTR_W-1:0] wr_gray_s;
  logic [PTR_W-1:0] wr_bin;
  logic             run_q;
  rxeb_err_e        verdict;
  rxeb_err_e        err_q;

  rxeb_gray_sync #(
    .W      (PTR_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(HALF_G)
  ) u_sync (
    .clk(rd_clk),
    .rst(rst),
    .d  (wr_gray_async),
    .q  (wr_gray_s)
  );

  assign wr_bin  = PTR_W'(rxeb_from_gray(rxeb_word_t'(wr_gray_s)));
  assign fill    = PTR_W'(rxeb_fill(rxeb_word_t'(wr_bin), rxeb_word_t'(rd_ptr), PTR_W));
  assign verdict = rxeb_judge(rxeb_word_t'(fill), OVER_ABOVE, UNDER_BELOW);
  assign unf_evt = (verdict == RXEB_UNDER);
  assign ovf_evt = (verdict == RXEB_OVER);
  assign rd_en   = run_q && !bypass;

  always_ff @(posedge rd_clk or posedge rst) begin
    if (rst) begin
      run_q  <= 1'b0;
      rd_ptr <= '0;
      err_q  <= RXEB_OK;
    end else if (bypass) begin
      run_q  <= 1'b0;
      rd_ptr <= '0;
      err_q  <= RXEB_OK;
    end else begin
      run_q <= 1'b1;
      if (run_q) rd_ptr <= rd_ptr + 1'b1;
      if (err_q == RXEB_OK && verdict != RXEB_OK) err_q <= verdict;
    end
  end

  assign err_code = err_q;

endmodule

// File: rtl/rx_elastic_ring.sv
module rx_elastic_ring #(
  parameter int unsigned PTR_W       = 6,
  parameter int unsigned DATA_W      = 10,
  parameter int unsigned STAT_W      = 3,
  parameter int unsigned NARROW_W    = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OVER_ABOVE  = 57,
  parameter int unsigned UNDER_BELOW = 17
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              bypass,
  input  logic              narrow,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STAT_W-1:0] wr_stat,
  output logic [DATA_W-1:0] rd_data,
  output logic [STAT_W-1:0] rd_stat,
  output logic [1:0]        err_code
);

  localparam int unsigned ENT_W = DATA_W + STAT_W;

  logic             wr_en_w;
  logic [PTR_W-1:0] wr_ptr_w;
  logic [PTR_W-1:0] wr_gray_w;
  logic [ENT_W-1:0] wr_entry_w;
  logic [ENT_W-1:0] byp_entry_w;
  logic             rd_en_w;
  logic [PTR_W-1:0] rd_ptr_w;
  logic [PTR_W-1:0] fill_w;
  logic             unf_w;
  logic             ovf_w;
  logic [ENT_W-1:0] ram_q;
  logic [ENT_W-1:0] out_entry;

  rxeb_wr_side #(
    .PTR_W   (PTR_W),
    .DATA_W  (DATA_W),
    .STAT_W  (STAT_W),
    .NARROW_W(NARROW_W),
    .ENT_W   (ENT_W)
  ) u_wr (
    .wr_clk   (wr_clk),
    .rst      (rst),
    .bypass   (bypass),
    .narrow   (narrow),
    .wr_data  (wr_data),
    .wr_stat  (wr_stat),
    .wr_en    (wr_en_w),
    .wr_ptr   (wr_ptr_w),
    .wr_gray  (wr_gray_w),
    .wr_entry (wr_entry_w),
    .byp_entry(byp_entry_w)
  );

  rxeb_ram #(
    .AW   (PTR_W),
    .ENT_W(ENT_W)
  ) u_ram (
    .wr_clk(wr_clk),
    .we    (wr_en_w),
    .waddr (wr_ptr_w),
    .wdata (wr_entry_w),
    .rd_clk(rd_clk),
    .re    (rd_en_w),
    .raddr (rd_ptr_w),
    .rdata (ram_q)
  );

  rxeb_rd_side #(
    .PTR_W      (PTR_W),
    .SYNC_STAGES(SYNC_STAGES),
    .OVER_ABOVE (OVER_ABOVE),
    .UNDER_BELOW(UNDER_BELOW)
  ) u_rd (
    .rd_clk       (rd_clk),
    .rst          (rst),
    .bypass       (bypass),
    .wr_gray_async(wr_gray_w),
    .rd_en        (rd_en_w),
    .rd_ptr       (rd_ptr_w),
    .fill         (fill_w),
    .unf_evt      (unf_w),
    .ovf_evt      (ovf_w),
    .err_code     (err_code)
  );

  assign out_entry = bypass ? byp_entry_w : ram_q;
  assign rd_data   = out_entry[DATA_W-1:0];
  assign rd_stat   = out_entry[ENT_W-1:DATA_W];

endmodule

// File: rtl/rxeb_chk.sv
module rxeb_chk #(
  parameter int unsigned PTR_W = 6
) (
  input logic             wr_clk,
  input logic             rd_clk,
  input logic             rst,
  input logic             bypass,
  input logic [1:0]       err_code,
  input logic [PTR_W-1:0] wr_ptr,
  input logic [PTR_W-1:0] rd_ptr,
  input logic             unf_evt,
  input logic             ovf_evt
);

  AST_WR_STEP: assert property (@(posedge wr_clk) disable iff (rst)
    !bypass |=> (bypass || wr_ptr == PTR_W'($past(wr_ptr) + 1'b1))); // R1

  AST_UNDER_FLAG: assert property (@(posedge rd_clk) disable iff (rst)
    (unf_evt && err_code == 2'b00 && !bypass) |=> (bypass || err_code == 2'b01)); // R4

  AST_OVER_FLAG: assert property (@(posedge rd_clk) disable iff (rst)
    (ovf_evt && err_code == 2'b00 && !bypass) |=> (bypass || err_code == 2'b10)); // R5

  AST_CODE_HOLD: assert property (@(posedge rd_clk) disable iff (rst)
    (err_code != 2'b00 && !bypass) |=> (bypass || err_code == $past(err_code))); // R6

  AST_BYPASS_PARK: assert property (@(posedge rd_clk) disable iff (rst)
    $past(bypass) |-> (err_code == 2'b00 && rd_ptr == '0)); // R9

  AST_CODE_LEGAL: assert property (@(posedge rd_clk) disable iff (rst)
    err_code != 2'b11); // R11

endmodule

bind rx_elastic_ring rxeb_chk #(.PTR_W(PTR_W)) u_chk (
  .wr_clk  (wr_clk),
  .rd_clk  (rd_clk),
  .rst     (rst),
  .bypass  (bypass),
  .err_code(err_code),
  .wr_ptr  (wr_ptr_w),
  .rd_ptr  (rd_ptr_w),
  .unf_evt (unf_w),
  .ovf_evt (ovf_w)
);

// File: tb/rx_elastic_ring_tb.sv
module rx_elastic_ring_tb_top;

  // one time unit stands for 1 ns: rd_clk period 8 (125 MHz)
  typedef struct packed {
    logic [9:0] d;
    logic [2:0] s;
    logic [9:0] d_narrow;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{10'h3FF, 3'd7, 10'h0FF},
    '{10'h000, 3'd0, 10'h000},
    '{10'h2A5, 3'd5, 10'h0A5},
    '{10'h15A, 3'd2, 10'h05A},
    '{10'h300, 3'd1, 10'h000},
    '{10'h0C3, 3'd6, 10'h0C3},
    '{10'h1FE, 3'd4, 10'h0FE},
    '{10'h201, 3'd3, 10'h001}
  };

  logic       wr_clk = 1'b0;
  logic       rd_clk = 1'b0;
  logic       rst = 1'b1;
  logic       bypass = 1'b0;
  logic       narrow = 1'b0;
  logic [9:0] wr_data = '0;
  logic [2:0] wr_stat = '0;
  logic [9:0] rd_data;
  logic [2:0] rd_stat;
  logic [1:0] err_code;

  int  checks = 0;
  int  fails = 0;
  int  wr_half = 4;
  bit  wr_on = 1'b1;
  bit  done = 1'b0;

  rx_elastic_ring dut_i (
    .wr_clk  (wr_clk),
    .rd_clk  (rd_clk),
    .rst     (rst),
    .bypass  (bypass),
    .narrow  (narrow),
    .wr_data (wr_data),
    .wr_stat (wr_stat),
    .rd_data (rd_data),
    .rd_stat (rd_stat),
    .err_code(err_code)
  );

  always #4 rd_clk = ~rd_clk;

  initial begin
    #1;
    forever begin
      #(wr_half);
      if (wr_on) wr_clk = ~wr_clk;
    end
  end

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_reset();
    rst = 1'b1;
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    rst = 1'b0;
  endtask

  // drain stream: entry m comes out after read edge 34+m (R3)
  task automatic stream_pass(input bit nar);
    narrow  = nar;
    wr_half = 4;
    wr_on   = 1'b1;
    wr_data = VECS[0].d;
    wr_stat = VECS[0].s;
    pulse_reset();
    fork
      begin
        for (int j = 1; j <= 40; j++) begin
          @(posedge wr_clk);
          @(negedge wr_clk);
          wr_data = VECS[j % 8].d;
          wr_stat = VECS[j % 8].s;
        end
      end
      begin
        for (int k = 1; k <= 49; k++) begin
          @(posedge rd_clk);
          @(negedge rd_clk);
          if (k >= 34) begin
            int m;
            int exp_d;
            m = k - 34;
            exp_d = nar ? int'(VECS[m % 8].d_narrow) : int'(VECS[m % 8].d);
            if (m == 0) check_eq("R3 first entry latency", int'(rd_data), exp_d);
            else if (nar) check_eq("R2 narrow data", int'(rd_data), exp_d);
            else check_eq("R1 data order", int'(rd_data), exp_d);
            check_eq("R1 status order", int'(rd_stat), int'(VECS[m % 8].s));
          end
        end
      end
    join
    check_eq("R10 no error at equal rates", int'(err_code), 0);
  endtask

  // write clock stopped: fill drops one per read edge from 32
  task automatic drain_to_underflow(input string tag_hold, input string tag_flag, input int tail);
    for (int k = 1; k <= 18 + tail; k++) begin
      @(posedge rd_clk);
      @(negedge rd_clk);
      if (k == 17) check_eq(tag_hold, int'(err_code), 0);
      if (k == 18) check_eq(tag_flag, int'(err_code), 1);
    end
  endtask

  initial begin
    repeat (2) @(negedge rd_clk);
    check_eq("R7 code clear in reset", int'(err_code), 0);

    // table walk, both data path sizes
    stream_pass(1'b0);
    stream_pass(1'b1);

    // underflow with exact timing, then sticky across the upper threshold
    wr_on = 1'b0;
    repeat (3) @(posedge rd_clk);
    pulse_reset();
    drain_to_underflow("R3 half full after reset", "R4 underflow edge", 30);
    check_eq("R6 underflow code held", int'(err_code), 1);
    @(negedge rd_clk);
    rst = 1'b1;
    #1;
    check_eq("R7 async clear", int'(err_code), 0);

    // overflow: write clock twice the read rate
    wr_half = 2;
    wr_on   = 1'b1;
    pulse_reset();
    repeat (40) @(posedge rd_clk);
    @(negedge rd_clk);
    check_eq("R5 overflow code", int'(err_code), 2);
    repeat (80) @(posedge rd_clk);
    @(negedge rd_clk);
    check_eq("R6 overflow code held", int'(err_code), 2);

    // bypass
    wr_half = 4;
    @(negedge rd_clk);
    bypass = 1'b1;
    repeat (3) @(posedge rd_clk);
    @(negedge rd_clk);
    check_eq("R9 code cleared in bypass", int'(err_code), 0);
    narrow = 1'b1;
    for (int v = 0; v < 4; v++) begin
      @(negedge wr_clk);
      wr_data = VECS[(v * 3) % 8].d;
      wr_stat = VECS[(v * 3) % 8].s;
      @(posedge wr_clk);
      #2;
      check_eq("R8 bypass data", int'(rd_data), int'(VECS[(v * 3) % 8].d));
      check_eq("R8 bypass status", int'(rd_stat), int'(VECS[(v * 3) % 8].s));
    end
    wr_on = 1'b0;
    repeat (4) @(posedge rd_clk);
    @(negedge rd_clk);
    bypass = 1'b0;
    drain_to_underflow("R9 parked at half full", "R9 fill timing after bypass", 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge rd_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule